// File: doc/BRIEF.md
# Probe Set Hit Scorer

This block scores one fixed silhouette template, a probe set, against a stream of image windows. A probe is a pair of pixel positions inside the window. It fires when the two pixels differ by more than a threshold. Each accepted window contributes a number of fired probes, the hit count. The count goes through a small table built for this set's size and comes out as a rank. No division takes place. Counts below the significance level give rank 0, and a fully matched template gives the highest rank.

The window advances by one image column for every accepted window. Some probes of the template sit on the same pixel pairs as other probes, shifted left by a few columns. Those probes are not compared again. The result of the matching probe is delayed in a 1-bit chain and tapped the right number of accepted windows later. Only the probes that are computed directly need window columns, so the window input stays narrow. The chain needs some warm-up. The first windows after reset only fill it, and they produce no score. The geometry, the threshold and the rank width are elaboration parameters.

States: `ST_PRIME` (filling the delay chains; scores are suppressed) and `ST_SCORE` (every accepted window yields a rank). Transitions: reset enters `ST_PRIME`, or `ST_SCORE` when no probe is reused. `ST_PRIME` moves to `ST_SCORE` on the valid window that completes the fill. `ST_SCORE` holds until reset.

Top module: `psh_scorer`

## Requirements
- R1: Pixel (r,c) of the window is `in_win[(r*4+c)*12 +: 12]`. Direct probe i (0..13) pairs pixel (i%2, (i/2)%4) with pixel (2+i/8, (i+1)%4). It fires only when the absolute difference of the two pixels is strictly greater than THRESH (100). A difference of exactly 100 does not fire.
- R2: The hit count of a scored window is the number of fired direct probes plus the number of fired reused probes, with a set size of 22.
- R3: Reused probe j (0..7) takes the result that direct probe j produced d valid windows earlier, with d = 3 + 2*(j%3), so the delays are 3, 5 and 7.
- R4: A hit count below ceil(22*80/100) = 18 gives rank 0.
- R5: A hit count h of 18 or more gives rank 1 + ((h-18)*6)/4. 22 hits give the maximum rank 7.
- R6: The rank of an accepted window appears with `out_valid` high exactly 3 clock cycles after the edge that samples `in_valid`. `out_valid` is high for one cycle per scored window.
- R7: The first 7 valid windows after reset (the longest delay) are consumed for priming and produce no `out_valid`. From the 8th valid window on, every valid window is scored.
- R8: After reset `out_valid` is 0 and `out_rank` is 0.
- R9: A cycle with `in_valid` low does not advance the delay chains or the priming count, and it produces no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Current window is valid and advances the stream by one column |
| in_win | input | 192 | 4x4 window of 12-bit unsigned pixels |
| out_valid | output | 1 | `out_rank` holds the rank of a scored window |
| out_rank | output | 3 | Rank of the window |

## Verification
A delay chain that shifts on the wrong cycle, or a tap set one stage off, does not show at once. The rank drifts only 3, 5 or 7 valid windows after the pixel contrast changes. So the bench changes the contrast abruptly, counts the reused hits that follow, and also puts idle cycles between windows. A priming counter that is off by one shows up as `out_valid` one window early or late around the 8th valid window. A wrong table entry shows up only at certain hit counts near the significance edge. Random windows biased toward 17 to 22 hits reach those counts.

// File: rtl/psh_pkg.sv
package psh_pkg;

    localparam int DEF_N_DIRECT = 14;
    localparam int DEF_N_REUSE  = 8;
    localparam int GEOM_FW      = 4;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_SCORE = 1'b1
    } psh_state_e;

    // Each direct probe: {row_a, col_a, row_b, col_b}, 4 bits each
    function automatic logic [DEF_N_DIRECT*16-1:0] make_direct_geom();
        logic [DEF_N_DIRECT*16-1:0] v;
        v = '0;
        for (int i = 0; i < DEF_N_DIRECT; i++) begin
            v[i*16 +: 16] = {4'(i % 2), 4'((i / 2) % 4), 4'(2 + i / 8), 4'((i + 1) % 4)};
        end
        return v;
    endfunction

    function automatic logic [DEF_N_REUSE*GEOM_FW-1:0] make_reuse_src();
        logic [DEF_N_REUSE*GEOM_FW-1:0] v;
        v = '0;
        for (int j = 0; j < DEF_N_REUSE; j++) v[j*GEOM_FW +: GEOM_FW] = 4'(j);
        return v;
    endfunction

    function automatic logic [DEF_N_REUSE*GEOM_FW-1:0] make_reuse_dly();
        logic [DEF_N_REUSE*GEOM_FW-1:0] v;
        v = '0;
        for (int j = 0; j < DEF_N_REUSE; j++) v[j*GEOM_FW +: GEOM_FW] = 4'(3 + 2 * (j % 3));
        return v;
    endfunction

    function automatic int sig_level(int n, int pct);
        return (n * pct + 99) / 100;
    endfunction

    // Monotone map from hit count to rank; no division at run time
    function automatic int rank_of(int h, int n, int sig, int rmax);
        if (h < sig)  return 0;
        if (n == sig) return rmax;
        return 1 + ((h - sig) * (rmax - 1)) / (n - sig);
    endfunction

endpackage

// File: rtl/psh_probe_array.sv
module psh_probe_array #(
    parameter int PIX_W    = 12,
    parameter int WIN_ROWS = 4,
    parameter int WIN_COLS = 4,
    parameter int N_DIRECT = 14,
    parameter logic [N_DIRECT*16-1:0] GEOM = '0,
    parameter int THRESH   = 100
) (
    input  logic [WIN_ROWS*WIN_COLS*PIX_W-1:0] win_i,
    output logic [N_DIRECT-1:0]                fire_o
);
    localparam logic [PIX_W-1:0] THR = THRESH[PIX_W-1:0];

    for (genvar i = 0; i < N_DIRECT; i++) begin : g_probe
        localparam int RA = int'(GEOM[i*16+12 +: 4]);
        localparam int CA = int'(GEOM[i*16+8  +: 4]);
        localparam int RB = int'(GEOM[i*16+4  +: 4]);
        localparam int CB = int'(GEOM[i*16    +: 4]);
        localparam int OFS_A = (RA * WIN_COLS + CA) * PIX_W;
        localparam int OFS_B = (RB * WIN_COLS + CB) * PIX_W;

        logic [PIX_W-1:0] pa, pb, mag;
        assign pa  = win_i[OFS_A +: PIX_W];
        assign pb  = win_i[OFS_B +: PIX_W];
        assign mag = (pa >= pb) ? (pa - pb) : (pb - pa);
        assign fire_o[i] = (mag > THR);
    end
endmodule

// File: rtl/psh_reuse_chain.sv
module psh_reuse_chain #(
    parameter int N_DIRECT = 14,
    parameter int N_REUSE  = 8,
    parameter int DEPTH    = 7,
    parameter logic [N_REUSE*4-1:0] SRC = '0,
    parameter logic [N_REUSE*4-1:0] DLY = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [N_DIRECT-1:0] fire_i,
    output logic [N_REUSE-1:0]  tap_o
);
    logic [N_DIRECT-1:0][DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en) begin
            for (int i = 0; i < N_DIRECT; i++) begin
                chain_q[i] <= DEPTH'({chain_q[i], fire_i[i]});
            end
        end
    end

    for (genvar j = 0; j < N_REUSE; j++) begin : g_tap
        localparam int S = int'(SRC[j*4 +: 4]);
        localparam int D = int'(DLY[j*4 +: 4]);
        assign tap_o[j] = chain_q[S][D-1];
    end

    // R9: idle cycles leave the history untouched
    assert_chain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/psh_rank_lut.sv
module psh_rank_lut #(
    parameter int N_SET   = 22,
    parameter int HIT_W   = 5,
    parameter int SIG_PCT = 80,
    parameter int RANK_W  = 3
) (
    input  logic [HIT_W-1:0]  hits_i,
    output logic [RANK_W-1:0] rank_o
);
    localparam int RANK_MAX = (1 << RANK_W) - 1;
    localparam int SIG_HITS = psh_pkg::sig_level(N_SET, SIG_PCT);

    logic [RANK_W-1:0] tbl [N_SET+1];

    for (genvar h = 0; h <= N_SET; h++) begin : g_entry
        assign tbl[h] = RANK_W'(psh_pkg::rank_of(h, N_SET, SIG_HITS, RANK_MAX));
    end

    always_comb begin
        rank_o = '0;
        if (int'(hits_i) <= N_SET) rank_o = tbl[hits_i];
    end

    // R5: a significant count never maps to rank 0
    always_comb begin
        if (!$isunknown(hits_i) && int'(hits_i) >= SIG_HITS && int'(hits_i) <= N_SET)
            assert_sig_nonzero_R5: assert (rank_o != '0);
    end
endmodule

// File: rtl/psh_scorer.sv
module psh_scorer #(
    parameter int PIX_W    = 12,
    parameter int WIN_ROWS = 4,
    parameter int WIN_COLS = 4,
    parameter int N_DIRECT = psh_pkg::DEF_N_DIRECT,
    parameter int N_REUSE  = psh_pkg::DEF_N_REUSE,
    parameter logic [N_DIRECT*16-1:0] DIRECT_GEOM = psh_pkg::make_direct_geom(),
    parameter logic [N_REUSE*4-1:0]   REUSE_SRC   = psh_pkg::make_reuse_src(),
    parameter logic [N_REUSE*4-1:0]   REUSE_DLY   = psh_pkg::make_reuse_dly(),
    parameter int THRESH   = 100,
    parameter int SIG_PCT  = 80,
    parameter int RANK_W   = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [WIN_ROWS*WIN_COLS*PIX_W-1:0] in_win,
    output logic                               out_valid,
    output logic [RANK_W-1:0]                  out_rank
);
    import psh_pkg::*;

    function automatic int find_max_dly();
        int m;
        m = 0;
        for (int j = 0; j < N_REUSE; j++) begin
            if (int'(REUSE_DLY[j*4 +: 4]) > m) m = int'(REUSE_DLY[j*4 +: 4]);
        end
        return m;
    endfunction

    localparam int N_SET    = N_DIRECT + N_REUSE;
    localparam int HIT_W    = $clog2(N_SET + 1);
    localparam int RANK_MAX = (1 << RANK_W) - 1;
    localparam int SIG_HITS = sig_level(N_SET, SIG_PCT);
    localparam int MAX_DLY  = find_max_dly();
    localparam int CH_DEPTH = (MAX_DLY < 1) ? 1 : MAX_DLY;
    localparam int PCW      = $clog2(CH_DEPTH + 1);
    localparam psh_state_e RST_STATE = (MAX_DLY == 0) ? ST_SCORE : ST_PRIME;

    // ---------------- control state machine ----------------
    psh_state_e       state_q, state_d;
    logic [PCW-1:0]   fill_q, fill_d;
    logic             accept, shift_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_PRIME: begin
                if (in_valid) begin
                    fill_d = fill_q + 1'b1;
                    if (int'(fill_q) == MAX_DLY - 1) state_d = ST_SCORE;
                end
            end
            ST_SCORE: begin
                state_d = ST_SCORE;
            end
        endcase
    end

    always_comb begin
        shift_en = in_valid;
        accept   = 1'b0;
        unique case (state_q)
            ST_PRIME: accept = 1'b0;
            ST_SCORE: accept = in_valid;
        endcase
    end

    // ---------------- probe evaluation ----------------
    logic [N_DIRECT-1:0] fire_now;
    logic [N_REUSE-1:0]  fire_old;

    psh_probe_array #(
        .PIX_W(PIX_W), .WIN_ROWS(WIN_ROWS), .WIN_COLS(WIN_COLS),
        .N_DIRECT(N_DIRECT), .GEOM(DIRECT_GEOM), .THRESH(THRESH)
    ) u_probes (
        .win_i (in_win),
        .fire_o(fire_now)
    );

    psh_reuse_chain #(
        .N_DIRECT(N_DIRECT), .N_REUSE(N_REUSE), .DEPTH(CH_DEPTH),
        .SRC(REUSE_SRC), .DLY(REUSE_DLY)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .fire_i  (fire_now),
        .tap_o   (fire_old)
    );

    // ---------------- three-stage scoring pipeline ----------------
    logic [N_SET-1:0]  bits_q;
    logic              v1_q, v2_q, v3_q;
    logic [HIT_W-1:0]  hits_d, hits_q;
    logic [RANK_W-1:0] rank_d, rank_q;

    always_comb begin
        hits_d = '0;
        for (int k = 0; k < N_SET; k++) hits_d = hits_d + HIT_W'(bits_q[k]);
    end

    psh_rank_lut #(
        .N_SET(N_SET), .HIT_W(HIT_W), .SIG_PCT(SIG_PCT), .RANK_W(RANK_W)
    ) u_lut (
        .hits_i(hits_q),
        .rank_o(rank_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            hits_q <= '0;
            rank_q <= '0;
            v1_q   <= 1'b0;
            v2_q   <= 1'b0;
            v3_q   <= 1'b0;
        end else begin
            v1_q <= accept;
            v2_q <= v1_q;
            v3_q <= v2_q;
            if (accept) bits_q <= {fire_old, fire_now};
            if (v1_q)   hits_q <= hits_d;
            if (v2_q)   rank_q <= rank_d;
        end
    end

    assign out_valid = v3_q;
    assign out_rank  = rank_q;

    // ---------------- assertions ----------------
    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == ST_SCORE) |-> ##3 out_valid);

    assert_prime_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |-> ##3 !out_valid);

    assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    assert_rank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_q && int'(hits_q) < SIG_HITS) |=> (out_rank == '0));

    assert_full_rank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_q && int'(hits_q) == N_SET) |=> (out_rank == RANK_W'(RANK_MAX)));

    assert_hits_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v2_q |-> (int'(hits_q) <= N_SET));
endmodule

// File: tb/psh_scorer_tb.sv
module psh_scorer_tb;
    localparam int PIX_W = 12;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int W     = ROWS * COLS * PIX_W;
    localparam int ND    = 14;
    localparam int NR    = 8;
    localparam int THR   = 100;
    localparam int SIG   = 18;
    localparam int MAXD  = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_win = '0;
    logic         out_valid;
    logic [2:0]   out_rank;

    always #10 clk = ~clk;

    psh_scorer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win),
        .out_valid(out_valid), .out_rank(out_rank)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    logic [ND-1:0] hist [1:MAXD];
    int            valid_seen = 0;
    logic          exp_v [3];
    logic [2:0]    exp_r [3];
    string         exp_t [3];

    function automatic int pix(logic [W-1:0] w, int r, int c);
        return int'(w[(r*COLS+c)*PIX_W +: PIX_W]);
    endfunction

    function automatic logic [ND-1:0] direct_bits(logic [W-1:0] w);
        logic [ND-1:0] b;
        for (int i = 0; i < ND; i++) begin
            int a, d;
            a = pix(w, i % 2, (i / 2) % 4);
            d = pix(w, 2 + i / 8, (i + 1) % 4);
            b[i] = ((a > d) ? a - d : d - a) > THR;
        end
        return b;
    endfunction

    function automatic int rank_model(int h);
        if (h < SIG) return 0;
        return 1 + ((h - SIG) * 6) / 4;
    endfunction

    function automatic logic [W-1:0] mk_win(int top, int bot);
        logic [W-1:0] w;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                w[(r*COLS+c)*PIX_W +: PIX_W] = PIX_W'((r < 2) ? top : bot);
        return w;
    endfunction

    task automatic fail_line(string tag, string what, int act, int expv);
        n_bad++;
        $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
    endtask

    // one clock step: check what is due now, then drive the next input
    task automatic step(logic [W-1:0] w, logic v, string tag);
        logic [ND-1:0] db;
        int            h;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== exp_v[2])
            fail_line(exp_t[2], "out_valid (R6 timing)", int'(out_valid), int'(exp_v[2]));
        else if (exp_v[2] && out_rank !== exp_r[2])
            fail_line(exp_t[2], "out_rank", int'(out_rank), int'(exp_r[2]));
        exp_v[2] = exp_v[1]; exp_r[2] = exp_r[1]; exp_t[2] = exp_t[1];
        exp_v[1] = exp_v[0]; exp_r[1] = exp_r[0]; exp_t[1] = exp_t[0];
        exp_v[0] = 1'b0; exp_r[0] = '0; exp_t[0] = tag;
        if (v) begin
            db = direct_bits(w);
            h  = $countones(db);
            for (int j = 0; j < NR; j++) h += int'(hist[3 + 2 * (j % 3)][j]);
            exp_v[0] = (valid_seen >= MAXD);
            exp_r[0] = 3'(rank_model(h));
            for (int d = MAXD; d > 1; d--) hist[d] = hist[d-1];
            hist[1] = db;
            valid_seen++;
        end
        in_valid = v;
        in_win   = w;
    endtask

    task automatic t_reset_R8();
        for (int d = 1; d <= MAXD; d++) hist[d] = '0;
        for (int k = 0; k < 3; k++) begin exp_v[k] = 1'b0; exp_r[k] = '0; exp_t[k] = "R8"; end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) fail_line("R8", "out_valid after reset", int'(out_valid), 0);
        n_cmp++;
        if (out_rank !== 3'd0) fail_line("R8", "out_rank after reset", int'(out_rank), 0);
    endtask

    task automatic t_prime_R7();
        int seen;
        seen = 0;
        for (int k = 0; k < MAXD; k++) begin
            step(mk_win(100, 1000), 1'b1, "R7");
            if (out_valid) seen++;
        end
        repeat (3) begin step(mk_win(0, 0), 1'b0, "R7"); if (out_valid) seen++; end
        n_cmp++;
        if (seen != 0) fail_line("R7", "scored windows during priming", seen, 0);
    endtask

    task automatic t_full_R5();
        repeat (4) step(mk_win(100, 1000), 1'b1, "R5");
    endtask

    task automatic t_threshold_R1();
        step(mk_win(500, 500 + THR), 1'b1, "R1");      // equal to threshold: no fire
        step(mk_win(500 + THR + 1, 500), 1'b1, "R1");  // one above: fires
        // reused hits of the quiet window surface at delays 3, 5 and 7
        repeat (8) step(mk_win(500, 500 + THR + 1), 1'b1, "R3");
    endtask

    task automatic t_zero_R4();
        repeat (9) step(mk_win(777, 777), 1'b1, "R4");
        repeat (3) step(mk_win(0, 4095), 1'b1, "R4");
    endtask

    task automatic t_idle_R9();
        for (int k = 0; k < 12; k++) begin
            step(mk_win(0, (k % 4 == 0) ? 50 : 3000), 1'b1, "R9");
            repeat (1 + k % 3) step(W'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}), 1'b0, "R9");
        end
    endtask

    task automatic t_random_R2();
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] w;
            w = mk_win(2000, 2000);
            for (int c = 0; c < COLS; c++) begin
                for (int r = 2; r < ROWS; r++) begin
                    int off;
                    if ($urandom_range(0, 99) < 90) off = THR + 1 + int'($urandom_range(0, 300));
                    else off = int'($urandom_range(0, THR));
                    if ($urandom_range(0, 1) == 1) off = -off;
                    w[(r*COLS+c)*PIX_W +: PIX_W] = PIX_W'(2000 + off);
                end
            end
            step(w, ($urandom_range(0, 7) != 0), "R2");
        end
    endtask

    initial begin
        t_reset_R8();
        t_prime_R7();
        t_full_R5();
        t_threshold_R1();
        t_zero_R4();
        t_idle_R9();
        t_random_R2();
        repeat (4) step(mk_win(0, 0), 1'b0, "R6");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule